// File: doc/BRIEF.md
# Byte-Bus Control Register Window Decoder

This block connects an 8-bit processor's banked byte port to the control and I/O register page of a 16-bit host system. Each byte access carries a 16-bit offset. The upper eight bits select a sub-page and bit 0 selects the byte lane. The decoder sorts every access into one of three classes. A valid access reaches a register. An unused access returns 0xFF and changes nothing. A lockup access returns 0xFF and stops the requester.

Valid targets are the I/O controller port, the bus-request/acknowledge bit, the secondary-CPU reset bit, a 16-bit timer window and the boot-ROM bank bit. The decoder holds the bus-request, reset and bank bits itself. The I/O controller and the timer are outside the block and are reached through plain read and write ports. A strobe completes in one cycle. Read data and the unused-access pulse are registered and appear one cycle after the strobe. A lockup latches a halt output unless the force-acknowledge input is set.

Top module: `ctrl_window_dec`

## Requirements
- R1: After reset, rd_data is 0x00, and rd_valid, unused_pulse, halt, busreq_bit, cpu_reset_bit and bank_bit are all 0.
- R2: A read in sub-page 0x00 with offset bits 7:5 all zero is valid. The cycle after the strobe, it returns io_rdata, with io_idx equal to offset bits 4:1. Any other read in sub-page 0x00 returns 0xFF and is unused.
- R3: io_wr_en is high during the strobe cycle only for a write in sub-page 0x00 with offset bits 7:5 zero and bit 0 set. Any other write in that sub-page leaves io_wr_en low and counts as unused.
- R4: An even-offset read in sub-page 0x11 returns 0xFF as a valid access. An odd-offset read there returns 0xFF and is unused.
- R5: An even-offset write in sub-page 0x11 loads busreq_bit from data bit 0. An even-offset write in sub-page 0x12 loads cpu_reset_bit from data bit 0. An odd-offset write in either sub-page is unused and changes neither bit.
- R6: An odd-offset read in sub-page 0x41 returns 0xFE OR bank_bit. An odd-offset write there loads bank_bit from data bit 0, but only while cfg_boot_en is 1. Otherwise the write is unused and bank_bit holds. An even-offset read there returns 0xFF and is unused.
- R7: When timer_present is 1, a read in sub-page 0x30 returns timer_rdata bits 7:0 at an odd offset and bits 15:8 at an even offset, and a write there pulses timer_wr_en during the strobe cycle. When timer_present is 0, every access there is unused and a read returns 0xFF.
- R8: Sub-pages 0x10, 0x20, 0x40, 0x44 and 0x50 are reserved. Reads there return 0xFF. Writes change no state and raise no write enable. Both are unused.
- R9: An access to any other sub-page is a lockup. A read returns 0xFF. If cfg_force_ack is 0, halt rises one cycle after the strobe and stays high until reset. If cfg_force_ack is 1, halt does not change.
- R10: unused_pulse is high for exactly the one cycle after the strobe of an unused access. It stays low after valid and lockup accesses. rd_valid is high for exactly the one cycle after each read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_force_ack | input | 1 | Suppresses halt on lockup accesses |
| cfg_boot_en | input | 1 | Permits writes to the bank bit |
| timer_present | input | 1 | Timer device fitted in the timer window |
| acc_strb | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte offset inside the control page |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| unused_pulse | output | 1 | One-cycle flag after an unused access |
| halt | output | 1 | Sticky stall request to the accessing CPU |
| io_idx | output | 4 | I/O controller register index |
| io_wr_en | output | 1 | I/O controller write enable |
| io_wdata | output | 8 | I/O controller write data |
| io_rdata | input | 8 | I/O controller read data |
| timer_wr_en | output | 1 | Timer window write enable |
| timer_waddr | output | 8 | Low offset byte passed to the timer |
| timer_wdata | output | 8 | Timer write data |
| timer_rdata | input | 16 | Timer register value |
| busreq_bit | output | 1 | Bus-request control bit |
| cpu_reset_bit | output | 1 | Secondary-CPU reset control bit |
| bank_bit | output | 1 | Boot-ROM bank selection bit |

## Verification
If the decoder puts an access in the wrong class, the error shows on unused_pulse or halt one cycle after the strobe. A wrong lane or register mapping shows as a wrong rd_data byte in that same cycle. A bad control-bit register shows on busreq_bit, cpu_reset_bit or bank_bit right after the write edge, and stays visible until the next write. The halt latch is sticky, so a false lockup never clears by itself. It is still visible at the end of each later scenario.

// File: rtl/ctrl_window_pkg.sv
package ctrl_window_pkg;

   typedef enum logic [1:0] {
      CLS_VALID  = 2'd0,
      CLS_UNUSED = 2'd1,
      CLS_LOCKUP = 2'd2
   } acc_cls_e;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_IO     = 3'd1,
      TGT_BUSACK = 3'd2,
      TGT_BUSREQ = 3'd3,
      TGT_RESET  = 3'd4,
      TGT_TIMER  = 3'd5,
      TGT_BANK   = 3'd6
   } acc_tgt_e;

   typedef struct packed {
      acc_cls_e cls;
      acc_tgt_e tgt;
      logic     odd;
   } dec_t;

   localparam logic [7:0] SP_IO     = 8'h00;
   localparam logic [7:0] SP_BUSARB = 8'h11;
   localparam logic [7:0] SP_CRESET = 8'h12;
   localparam logic [7:0] SP_TIMER  = 8'h30;
   localparam logic [7:0] SP_BANK   = 8'h41;

   function automatic logic sp_reserved(input logic [7:0] sp);
      return (sp == 8'h10) || (sp == 8'h20) || (sp == 8'h40) ||
             (sp == 8'h44) || (sp == 8'h50);
   endfunction

   localparam int NUM_CBITS = 3;
   localparam int CB_BUSREQ = 0;
   localparam int CB_RESET  = 1;
   localparam int CB_BANK   = 2;

endpackage

// File: rtl/cwd_decode.sv
module cwd_decode
   import ctrl_window_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              boot_en,
   input  logic              timer_ok,
   output dec_t              dec
);
   localparam int SP_LSB = 8;

   logic [7:0] sp;
   logic [7:0] lo;

   assign sp = addr[SP_LSB +: 8];
   assign lo = addr[7:0];

   always_comb begin
      dec.cls = CLS_UNUSED;
      dec.tgt = TGT_NONE;
      dec.odd = lo[0];
      unique case (sp)
         SP_IO: begin
            if (wr ? ((lo & 8'hE1) == 8'h01) : (lo[7:5] == 3'b000)) begin
               dec.cls = CLS_VALID;
               dec.tgt = TGT_IO;
            end
         end
         SP_BUSARB: begin
            if (!lo[0]) begin
               dec.cls = CLS_VALID;
               dec.tgt = wr ? TGT_BUSREQ : TGT_BUSACK;
            end
         end
         SP_CRESET: begin
            if (wr && !lo[0]) begin
               dec.cls = CLS_VALID;
               dec.tgt = TGT_RESET;
            end
         end
         SP_TIMER: begin
            if (timer_ok) begin
               dec.cls = CLS_VALID;
               dec.tgt = TGT_TIMER;
            end
         end
         SP_BANK: begin
            if (lo[0] && (!wr || boot_en)) begin
               dec.cls = CLS_VALID;
               dec.tgt = TGT_BANK;
            end
         end
         default: begin
            if (!sp_reserved(sp)) dec.cls = CLS_LOCKUP;
         end
      endcase
   end
endmodule

// File: rtl/cwd_ctrl_regs.sv
module cwd_ctrl_regs
   import ctrl_window_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [NUM_CBITS-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strb,
   input  logic              wr,
   input  dec_t              dec,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CBITS-1:0] bits_q
);
   localparam acc_tgt_e TGT_OF [NUM_CBITS] = '{TGT_BUSREQ, TGT_RESET, TGT_BANK};

   logic wr_valid;
   assign wr_valid = strb && wr && (dec.cls == CLS_VALID);

   for (genvar i = 0; i < NUM_CBITS; i++) begin : g_cbit
      always_ff @(posedge clk) begin
         if (!rst_n)
            bits_q[i] <= RST_VAL[i];
         else if (wr_valid && (dec.tgt == TGT_OF[i]))
            bits_q[i] <= wdata[0];
      end
   end
endmodule

// File: rtl/cwd_read_path.sv
module cwd_read_path
   import ctrl_window_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strb,
   input  logic                wr,
   input  dec_t                dec,
   input  logic [DATA_W-1:0]   io_rdata,
   input  logic [2*DATA_W-1:0] timer_rdata,
   input  logic                bank_bit,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   output logic                unused_pulse
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = ALL_ONES;
      if (dec.cls == CLS_VALID) begin
         unique case (dec.tgt)
            TGT_IO:    rd_next = io_rdata;
            TGT_TIMER: rd_next = dec.odd ? timer_rdata[DATA_W-1:0]
                                         : timer_rdata[2*DATA_W-1:DATA_W];
            TGT_BANK:  rd_next = {ALL_ONES[DATA_W-1:1], bank_bit};
            default:   rd_next = ALL_ONES;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data      <= '0;
         rd_valid     <= 1'b0;
         unused_pulse <= 1'b0;
      end else begin
         rd_valid     <= strb && !wr;
         unused_pulse <= strb && (dec.cls == CLS_UNUSED);
         if (strb && !wr) rd_data <= rd_next;
      end
   end
endmodule

// File: rtl/cwd_halt.sv
module cwd_halt
   import ctrl_window_pkg::*;
#(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strb,
   input  dec_t dec,
   input  logic force_ack,
   output logic halt_q
);
   logic trip;
   assign trip = strb && (dec.cls == CLS_LOCKUP) && !force_ack;

   if (STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)    halt_q <= 1'b0;
         else if (trip) halt_q <= 1'b1;
      end
   end else begin : g_pulse
      always_ff @(posedge clk) begin
         if (!rst_n) halt_q <= 1'b0;
         else        halt_q <= trip;
      end
   end
endmodule

// File: rtl/ctrl_window_dec.sv
module ctrl_window_dec
   import ctrl_window_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int IO_IDX_W    = 4,
   parameter bit TIMER_EN    = 1'b1,
   parameter bit HALT_STICKY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_force_ack,
   input  logic                cfg_boot_en,
   input  logic                timer_present,
   input  logic                acc_strb,
   input  logic                acc_wr,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [DATA_W-1:0]   acc_wdata,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   output logic                unused_pulse,
   output logic                halt,
   output logic [IO_IDX_W-1:0] io_idx,
   output logic                io_wr_en,
   output logic [DATA_W-1:0]   io_wdata,
   input  logic [DATA_W-1:0]   io_rdata,
   output logic                timer_wr_en,
   output logic [7:0]          timer_waddr,
   output logic [DATA_W-1:0]   timer_wdata,
   input  logic [2*DATA_W-1:0] timer_rdata,
   output logic                busreq_bit,
   output logic                cpu_reset_bit,
   output logic                bank_bit
);
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ctrl_window_dec: ADDR_W must be at least 16");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("ctrl_window_dec: DATA_W must be 8");
   end
   if (IO_IDX_W != 4) begin : g_bad_idx
      $error("ctrl_window_dec: IO_IDX_W must be 4");
   end

   dec_t                 dec;
   logic                 timer_ok;
   logic [NUM_CBITS-1:0] cbits;
   logic                 wr_valid;

   if (TIMER_EN) begin : g_timer
      assign timer_ok = timer_present;
   end else begin : g_no_timer
      assign timer_ok = 1'b0;
   end

   cwd_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr     (acc_addr),
      .wr       (acc_wr),
      .boot_en  (cfg_boot_en),
      .timer_ok (timer_ok),
      .dec      (dec)
   );

   cwd_ctrl_regs #(.DATA_W(DATA_W), .RST_VAL('0)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (acc_strb),
      .wr     (acc_wr),
      .dec    (dec),
      .wdata  (acc_wdata),
      .bits_q (cbits)
   );

   cwd_read_path #(.DATA_W(DATA_W)) u_read (
      .clk          (clk),
      .rst_n        (rst_n),
      .strb         (acc_strb),
      .wr           (acc_wr),
      .dec          (dec),
      .io_rdata     (io_rdata),
      .timer_rdata  (timer_rdata),
      .bank_bit     (cbits[CB_BANK]),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid),
      .unused_pulse (unused_pulse)
   );

   cwd_halt #(.STICKY(HALT_STICKY)) u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb      (acc_strb),
      .dec       (dec),
      .force_ack (cfg_force_ack),
      .halt_q    (halt)
   );

   assign wr_valid      = acc_strb && acc_wr && (dec.cls == CLS_VALID);
   assign io_wr_en      = wr_valid && (dec.tgt == TGT_IO);
   assign timer_wr_en   = wr_valid && (dec.tgt == TGT_TIMER);
   assign io_idx        = acc_addr[IO_IDX_W:1];
   assign io_wdata      = acc_wdata;
   assign timer_wdata   = acc_wdata;
   assign timer_waddr   = acc_addr[7:0];
   assign busreq_bit    = cbits[CB_BUSREQ];
   assign cpu_reset_bit = cbits[CB_RESET];
   assign bank_bit      = cbits[CB_BANK];
endmodule

// File: rtl/ctrl_window_chk.sv
module ctrl_window_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_force_ack,
   input logic              cfg_boot_en,
   input logic              acc_strb,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              rd_valid,
   input logic              unused_pulse,
   input logic              halt,
   input logic              io_wr_en,
   input logic              busreq_bit,
   input logic              cpu_reset_bit,
   input logic              bank_bit
);
   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> halt);

   assert_halt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> ($past(acc_strb) && !$past(cfg_force_ack)));

   assert_rdvalid_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_strb && !acc_wr));

   assert_unused_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unused_pulse |-> $past(acc_strb));

   assert_io_write_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr_en |-> (acc_strb && acc_wr && acc_addr[0] && (acc_addr[7:5] == 3'b000)));

   assert_busreq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_strb && acc_wr) |=> ($stable(busreq_bit) && $stable(cpu_reset_bit)));

   assert_bank_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_strb && acc_wr && cfg_boot_en) |=> $stable(bank_bit));
endmodule

bind ctrl_window_dec ctrl_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_force_ack (cfg_force_ack),
   .cfg_boot_en   (cfg_boot_en),
   .acc_strb      (acc_strb),
   .acc_wr        (acc_wr),
   .acc_addr      (acc_addr),
   .rd_valid      (rd_valid),
   .unused_pulse  (unused_pulse),
   .halt          (halt),
   .io_wr_en      (io_wr_en),
   .busreq_bit    (busreq_bit),
   .cpu_reset_bit (cpu_reset_bit),
   .bank_bit      (bank_bit)
);

// File: tb/ctrl_window_dec_tb_top.sv
module ctrl_window_dec_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_force_ack = 1'b0;
   logic        cfg_boot_en = 1'b0;
   logic        timer_present = 1'b1;
   logic        acc_strb = 1'b0;
   logic        acc_wr = 1'b0;
   logic [15:0] acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  rd_data;
   logic        rd_valid, unused_pulse, halt;
   logic [3:0]  io_idx;
   logic        io_wr_en;
   logic [7:0]  io_wdata;
   logic [7:0]  io_rdata = 8'h5A;
   logic        timer_wr_en;
   logic [7:0]  timer_waddr;
   logic [7:0]  timer_wdata;
   logic [15:0] timer_rdata = 16'hBEEF;
   logic        busreq_bit, cpu_reset_bit, bank_bit;

   int n_chk = 0;
   int n_bad = 0;

   // Sampled per access
   logic       s_iowr, s_tmwr;
   logic [3:0] s_idx;
   logic [7:0] s_iowd;

   always #4 clk = ~clk;

   ctrl_window_dec dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_force_ack(cfg_force_ack), .cfg_boot_en(cfg_boot_en),
      .timer_present(timer_present), .acc_strb(acc_strb), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .unused_pulse(unused_pulse), .halt(halt), .io_idx(io_idx), .io_wr_en(io_wr_en),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .timer_wr_en(timer_wr_en),
      .timer_waddr(timer_waddr), .timer_wdata(timer_wdata), .timer_rdata(timer_rdata),
      .busreq_bit(busreq_bit), .cpu_reset_bit(cpu_reset_bit), .bank_bit(bank_bit)
   );

   task automatic check(input string req, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive one strobe at a falling edge; sample combinational enables before
   // the rising edge and registered outputs at the next falling edge.
   task automatic access(input logic wr, input logic [15:0] addr, input logic [7:0] d);
      @(negedge clk);
      acc_strb = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = d;
      #1;
      s_iowr = io_wr_en; s_tmwr = timer_wr_en; s_idx = io_idx; s_iowd = io_wdata;
      @(negedge clk);
      acc_strb = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic t_reset;
      check("R1", "rd_data", {8'h0, rd_data}, 16'h0000);
      check("R1", "rd_valid", {15'h0, rd_valid}, 16'h0);
      check("R1", "unused", {15'h0, unused_pulse}, 16'h0);
      check("R1", "halt", {15'h0, halt}, 16'h0);
      check("R1", "ctrl bits", {13'h0, busreq_bit, cpu_reset_bit, bank_bit}, 16'h0);
   endtask

   task automatic t_io;
      access(1'b0, 16'h000A, 8'h00);
      check("R2", "io read data", {8'h0, rd_data}, 16'h005A);
      check("R2", "io index", {12'h0, s_idx}, 16'h0005);
      check("R2", "io read unused", {15'h0, unused_pulse}, 16'h0);
      check("R10", "rd_valid", {15'h0, rd_valid}, 16'h1);
      access(1'b0, 16'h0020, 8'h00);
      check("R2", "io bad read data", {8'h0, rd_data}, 16'h00FF);
      check("R2", "io bad read unused", {15'h0, unused_pulse}, 16'h1);
      access(1'b1, 16'h0003, 8'h33);
      check("R3", "io write en", {15'h0, s_iowr}, 16'h1);
      check("R3", "io write data", {8'h0, s_iowd}, 16'h0033);
      check("R10", "rd_valid after write", {15'h0, rd_valid}, 16'h0);
      access(1'b1, 16'h0002, 8'h44);
      check("R3", "io even write en", {15'h0, s_iowr}, 16'h0);
      check("R3", "io even write unused", {15'h0, unused_pulse}, 16'h1);
      access(1'b1, 16'h0041, 8'h44);
      check("R3", "io high write en", {15'h0, s_iowr}, 16'h0);
   endtask

   task automatic t_busack;
      access(1'b0, 16'h1100, 8'h00);
      check("R4", "ack even data", {8'h0, rd_data}, 16'h00FF);
      check("R4", "ack even unused", {15'h0, unused_pulse}, 16'h0);
      access(1'b0, 16'h1101, 8'h00);
      check("R4", "ack odd unused", {15'h0, unused_pulse}, 16'h1);
   endtask

   task automatic t_ctrl_bits;
      access(1'b1, 16'h1100, 8'h01);
      check("R5", "busreq set", {15'h0, busreq_bit}, 16'h1);
      access(1'b1, 16'h1101, 8'h00);
      check("R5", "busreq odd ignored", {15'h0, busreq_bit}, 16'h1);
      check("R5", "busreq odd unused", {15'h0, unused_pulse}, 16'h1);
      access(1'b1, 16'h1200, 8'h03);
      check("R5", "reset set", {15'h0, cpu_reset_bit}, 16'h1);
      access(1'b1, 16'h1201, 8'h00);
      check("R5", "reset odd ignored", {15'h0, cpu_reset_bit}, 16'h1);
      access(1'b1, 16'h1100, 8'h02);
      check("R5", "busreq clear by bit0", {15'h0, busreq_bit}, 16'h0);
   endtask

   task automatic t_bank;
      cfg_boot_en = 1'b0;
      access(1'b1, 16'h4101, 8'h01);
      check("R6", "bank locked", {15'h0, bank_bit}, 16'h0);
      check("R6", "bank locked unused", {15'h0, unused_pulse}, 16'h1);
      cfg_boot_en = 1'b1;
      access(1'b1, 16'h4101, 8'h01);
      check("R6", "bank set", {15'h0, bank_bit}, 16'h1);
      access(1'b0, 16'h4101, 8'h00);
      check("R6", "bank read 1", {8'h0, rd_data}, 16'h00FF);
      access(1'b1, 16'h4100, 8'h00);
      check("R6", "bank even write ignored", {15'h0, bank_bit}, 16'h1);
      access(1'b1, 16'h4101, 8'h00);
      access(1'b0, 16'h4101, 8'h00);
      check("R6", "bank read 0", {8'h0, rd_data}, 16'h00FE);
      access(1'b0, 16'h4100, 8'h00);
      check("R6", "bank even read", {8'h0, rd_data}, 16'h00FF);
      check("R6", "bank even read unused", {15'h0, unused_pulse}, 16'h1);
   endtask

   task automatic t_timer;
      timer_present = 1'b1;
      access(1'b0, 16'h3001, 8'h00);
      check("R7", "timer low", {8'h0, rd_data}, 16'h00EF);
      access(1'b0, 16'h3000, 8'h00);
      check("R7", "timer high", {8'h0, rd_data}, 16'h00BE);
      access(1'b1, 16'h3005, 8'h77);
      check("R7", "timer write en", {15'h0, s_tmwr}, 16'h1);
      timer_present = 1'b0;
      access(1'b0, 16'h3001, 8'h00);
      check("R7", "absent timer data", {8'h0, rd_data}, 16'h00FF);
      check("R7", "absent timer unused", {15'h0, unused_pulse}, 16'h1);
      access(1'b1, 16'h3005, 8'h77);
      check("R7", "absent timer write en", {15'h0, s_tmwr}, 16'h0);
      timer_present = 1'b1;
   endtask

   task automatic t_reserved;
      logic [7:0] rsv [5] = '{8'h10, 8'h20, 8'h40, 8'h44, 8'h50};
      access(1'b1, 16'h1100, 8'h01);
      for (int i = 0; i < 5; i++) begin
         access(1'b0, {rsv[i], 8'h01}, 8'h00);
         check("R8", "reserved read", {8'h0, rd_data}, 16'h00FF);
         check("R8", "reserved read unused", {15'h0, unused_pulse}, 16'h1);
         access(1'b1, {rsv[i], 8'h00}, 8'h00);
         check("R8", "reserved write unused", {15'h0, unused_pulse}, 16'h1);
         check("R8", "reserved state", {13'h0, busreq_bit, halt, s_iowr}, 16'h0004);
      end
   endtask

   task automatic t_lockup;
      cfg_force_ack = 1'b1;
      access(1'b0, 16'h7701, 8'h00);
      check("R9", "lockup data", {8'h0, rd_data}, 16'h00FF);
      check("R9", "forced ack halt", {15'h0, halt}, 16'h0);
      check("R10", "lockup not unused", {15'h0, unused_pulse}, 16'h0);
      cfg_force_ack = 1'b0;
      access(1'b1, 16'h5500, 8'h00);
      check("R9", "halt raised", {15'h0, halt}, 16'h1);
      access(1'b0, 16'h1100, 8'h00);
      check("R9", "halt sticky", {15'h0, halt}, 16'h1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R9", "halt cleared by reset", {15'h0, halt}, 16'h0);
      check("R1", "ctrl after reset", {13'h0, busreq_bit, cpu_reset_bit, bank_bit}, 16'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_io();
      t_busack();
      t_ctrl_bits();
      t_bank();
      t_timer();
      t_reserved();
      t_lockup();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule